// File: doc/BRIEF.md
# Line Code Violation Detector

This block watches a recovered dual-rail bipolar bit stream and reports line-code errors. Each recovered clock cycle carries one bit period, given as a positive-pulse rail and a negative-pulse rail that are already synchronous to the clock. A two-bit code select chooses the rule set: alternate mark inversion, bipolar with eight-zero substitution, or high-density bipolar of order three.

Two kinds of error are reported. The first is a bipolar or code violation: a mark whose polarity breaks the rules of the selected code. The second is an excessive-zero event: a run of zeros whose length depends on the code. Legal substitution violations are accepted and are not reported. Each error type drives a one-cycle strobe and a 16-bit saturating event counter. A single clear pulse resets both counters. The block is meant to sit behind the slicer and clock recovery of a line interface. It does not decode the substituted patterns back to zeros.

Top module: `lcv_monitor`

## Requirements
- R1: With code select 0 (alternate mark inversion), or with the unused code 3, a mark whose polarity matches the previous mark produces a violation, whatever number of zeros lies between the two. A pulse on the positive rail is polarity +, a pulse on the negative rail is polarity -.
- R2: A bit period with both rails high is a violation in every code. It ends the zero run and erases the polarity history, so the next single-rail mark is not compared with anything.
- R3: With code select 1 (eight-zero substitution), a same-polarity mark is accepted only when it opens the sequence 000VB0VB: exactly three zeros, then V, then a B of opposite polarity, then a zero, then V, then B. If such a sequence breaks off, a violation is reported at the first bit that departs from it. Every other same-polarity mark is a violation.
- R4: With code select 2 (third-order high density), a mark with the same polarity as the previous mark is a violation pulse. It is reported as a code violation only when its polarity equals that of the previous violation pulse.
- R5: The excessive-zero strobe fires on the bit that completes a run of 16 zeros in codes 0 and 3, of 8 zeros in code 1, and of 4 zeros in code 2.
- R6: After the excessive-zero strobe has fired, longer runs of zeros do not fire it again until a mark has been received.
- R7: After reset, and on the bit at which the code select changes, the polarity history and the zero run are cleared, so the first single-rail mark never produces a violation.
- R8: Each strobe adds one to its 16-bit counter, and a counter at 65535 stays at 65535.
- R9: A clear pulse sets both counters to zero. An error in the same bit period is still counted, so that counter reads 1.
- R10: The strobes and counters are registered and show the result for a bit one clock after that bit is sampled. After reset all of them are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered line clock, one bit period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_sel_i | input | 2 | Line code: 0 alternate mark inversion, 1 eight-zero substitution, 2 third-order high density, 3 same as 0 |
| pos_i | input | 1 | Positive-pulse rail |
| neg_i | input | 1 | Negative-pulse rail |
| cnt_clr_i | input | 1 | Clears both error counters |
| viol_o | output | 1 | One-cycle bipolar or code violation strobe |
| exz_o | output | 1 | One-cycle excessive-zero strobe |
| viol_cnt_o | output | 16 | Saturating violation count |
| exz_cnt_o | output | 16 | Saturating excessive-zero count |

## Verification
The counter clear pulse and a counted error can fall in the same bit period. The bench provokes this by raising the clear together with a both-rails bit, once a violation count has saturated and an excessive-zero count has built up. It expects the violation counter to read exactly 1 and the zero counter to read 0. A second case is an early break in an eight-zero substitution, where the departing bit is itself a zero. There the violation comes from the broken pattern and not from a polarity pair, and the bench's own reference model decides whether it is flagged.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
  typedef enum logic [1:0] {
    LC_AMI  = 2'd0,
    LC_B8ZS = 2'd1,
    LC_HDB3 = 2'd2,
    LC_RSVD = 2'd3
  } lcode_e;

  localparam logic [2:0] SQ_IDLE = 3'd0;
  localparam logic [2:0] SQ_B1   = 3'd1;
  localparam logic [2:0] SQ_Z    = 3'd2;
  localparam logic [2:0] SQ_V2   = 3'd3;
  localparam logic [2:0] SQ_B2   = 3'd4;
endpackage

// File: rtl/lcv_zero_run.sv
module lcv_zero_run #(
  parameter int ZW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          mark_i,
  input  logic [ZW-1:0] thr_i,
  output logic [ZW-1:0] zrun_o,
  output logic          exz_o
);
  localparam logic [ZW-1:0] ZMAX = {ZW{1'b1}};

  logic [ZW-1:0] zrun_q, zrun_n, zbase;

  always_comb begin
    zbase = flush_i ? '0 : zrun_q;
    if (mark_i)
      zrun_n = '0;
    else if (zbase == ZMAX)
      zrun_n = zbase;
    else
      zrun_n = zbase + 1'b1;
    exz_o = ~mark_i & (zrun_n == thr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      zrun_q <= '0;
    else
      zrun_q <= zrun_n;
  end

  assign zrun_o = zrun_q;

  AST_ZRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mark_i |=> (zrun_q == '0)); // R5

  AST_EXZ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (exz_o && thr_i > 1 && !mark_i) |=> !(exz_o && !flush_i)); // R6
endmodule

// File: rtl/lcv_polarity.sv
module lcv_polarity
  import lcv_pkg::*;
#(
  parameter int ZW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lcode_e        code_i,
  input  logic          flush_i,
  input  logic          pos_i,
  input  logic          neg_i,
  input  logic [ZW-1:0] zrun_i,
  output logic          viol_o
);
  logic       mvld_q, mpol_q, vvld_q, vpol_q;
  logic       mvld_n, mpol_n, vvld_n, vpol_n;
  logic [2:0] seq_q, seq_n, h_seq;
  logic       h_mvld, h_vvld, mark, both, same, alt;
  logic [ZW-1:0] zr;

  always_comb begin
    h_mvld = mvld_q & ~flush_i;
    h_vvld = vvld_q & ~flush_i;
    h_seq  = flush_i ? SQ_IDLE : seq_q;
    zr     = flush_i ? '0 : zrun_i;
    mark   = pos_i ^ neg_i;
    both   = pos_i & neg_i;
    same   = mark & h_mvld & (pos_i == mpol_q);
    alt    = mark & h_mvld & (pos_i != mpol_q);

    mvld_n = h_mvld;
    mpol_n = mpol_q;
    vvld_n = h_vvld;
    vpol_n = vpol_q;
    seq_n  = SQ_IDLE;
    viol_o = 1'b0;

    if (both) begin
      viol_o = 1'b1;
      mvld_n = 1'b0;
    end else begin
      if (mark) begin
        mvld_n = 1'b1;
        mpol_n = pos_i;
      end
      case (code_i)
        LC_HDB3: begin
          if (same) begin
            viol_o = h_vvld & (pos_i == vpol_q);
            vvld_n = 1'b1;
            vpol_n = pos_i;
          end
        end
        LC_B8ZS: begin
          case (h_seq)
            SQ_IDLE: if (same) begin
                       if (zr == ZW'(3)) seq_n = SQ_B1;
                       else              viol_o = 1'b1;
                     end
            SQ_B1:   if (alt)   seq_n = SQ_Z;  else viol_o = 1'b1;
            SQ_Z:    if (!mark) seq_n = SQ_V2; else viol_o = 1'b1;
            SQ_V2:   if (same)  seq_n = SQ_B2; else viol_o = 1'b1;
            SQ_B2:   if (!alt)  viol_o = 1'b1;
            default: seq_n = SQ_IDLE;
          endcase
        end
        default: viol_o = same;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mvld_q <= 1'b0;
      mpol_q <= 1'b0;
      vvld_q <= 1'b0;
      vpol_q <= 1'b0;
      seq_q  <= SQ_IDLE;
    end else begin
      mvld_q <= mvld_n;
      mpol_q <= mpol_n;
      vvld_q <= vvld_n;
      vpol_q <= vpol_n;
      seq_q  <= seq_n;
    end
  end

  AST_SEQ_ONLY_B8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i != LC_B8ZS) |=> (seq_q == SQ_IDLE)); // R3

  AST_BOTH_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_i & neg_i) |=> !mvld_q); // R2
endmodule

// File: rtl/lcv_sat_cnt.sv
module lcv_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_n, base;
  logic         en;

  always_comb begin
    en    = clr_i | inc_i;
    base  = clr_i ? '0 : cnt_q;
    cnt_n = (inc_i && base != CMAX) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (en)
      cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !clr_i) |=> (cnt_q == CMAX)); // R8

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R8

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !inc_i) |=> (cnt_q == '0)); // R9

  AST_CLR_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && inc_i) |=> (cnt_q == W'(1))); // R9
endmodule

// File: rtl/lcv_monitor.sv
module lcv_monitor
  import lcv_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int AMI_EXZ  = 16,
  parameter int B8ZS_EXZ = 8,
  parameter int HDB3_EXZ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       code_sel_i,
  input  logic             pos_i,
  input  logic             neg_i,
  input  logic             cnt_clr_i,
  output logic             viol_o,
  output logic             exz_o,
  output logic [CNT_W-1:0] viol_cnt_o,
  output logic [CNT_W-1:0] exz_cnt_o
);
  localparam int MAX_A = (AMI_EXZ > B8ZS_EXZ) ? AMI_EXZ : B8ZS_EXZ;
  localparam int MAX_T = (MAX_A > HDB3_EXZ) ? MAX_A : HDB3_EXZ;
  localparam int ZW    = $clog2(MAX_T) + 1;
  localparam int NEV   = 2;

  logic          rst_meta, rst_sync;
  lcode_e        code, code_q;
  logic          flush, mark, viol_c, exz_c;
  logic          viol_q, exz_q;
  logic [ZW-1:0] thr, zrun;
  logic [NEV-1:0]  evt;
  logic [CNT_W-1:0] cnt [NEV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    code  = lcode_e'(code_sel_i);
    flush = (code != code_q);
    mark  = pos_i | neg_i;
    case (code)
      LC_B8ZS: thr = ZW'(B8ZS_EXZ);
      LC_HDB3: thr = ZW'(HDB3_EXZ);
      default: thr = ZW'(AMI_EXZ);
    endcase
  end

  lcv_zero_run #(.ZW(ZW)) u_zero (
    .clk    (clk),
    .rst_n  (rst_sync),
    .flush_i(flush),
    .mark_i (mark),
    .thr_i  (thr),
    .zrun_o (zrun),
    .exz_o  (exz_c)
  );

  lcv_polarity #(.ZW(ZW)) u_pol (
    .clk    (clk),
    .rst_n  (rst_sync),
    .code_i (code),
    .flush_i(flush),
    .pos_i  (pos_i),
    .neg_i  (neg_i),
    .zrun_i (zrun),
    .viol_o (viol_c)
  );

  assign evt = {exz_c, viol_c};

  for (genvar g = 0; g < NEV; g++) begin : g_cnt
    lcv_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_sync),
      .clr_i(cnt_clr_i),
      .inc_i(evt[g]),
      .cnt_o(cnt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      code_q <= LC_AMI;
      viol_q <= 1'b0;
      exz_q  <= 1'b0;
    end else begin
      code_q <= code;
      viol_q <= viol_c;
      exz_q  <= exz_c;
    end
  end

  assign viol_o     = viol_q;
  assign exz_o      = exz_q;
  assign viol_cnt_o = cnt[0];
  assign exz_cnt_o  = cnt[1];

  AST_BOTH_RAILS: assert property (@(posedge clk) disable iff (!rst_sync)
    (pos_i & neg_i) |=> viol_o); // R2

  AST_FRESH_HISTORY: assert property (@(posedge clk) disable iff (!rst_sync)
    (flush && !(pos_i & neg_i)) |=> !viol_o); // R7

  AST_ZERO_NO_POLARITY: assert property (@(posedge clk) disable iff (!rst_sync)
    (!mark && code != LC_B8ZS) |=> !viol_o); // R1

  AST_MARK_NO_EXZ: assert property (@(posedge clk) disable iff (!rst_sync)
    mark |=> !exz_o); // R5
endmodule

// File: tb/lcv_monitor_tb.sv
module lcv_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  code_sel;
  logic        pos, neg, clr;
  logic        viol, exz;
  logic [15:0] vcnt, zcnt;

  int checks = 0;
  int fails  = 0;
  string tag = "R10";

  // reference state
  int m_lm, m_lv, m_zr, m_pend, m_prev;
  int e_vc, e_zc;
  int gen_last;

  always #2 clk = ~clk;

  lcv_monitor u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_sel_i(code_sel),
    .pos_i     (pos),
    .neg_i     (neg),
    .cnt_clr_i (clr),
    .viol_o    (viol),
    .exz_o     (exz),
    .viol_cnt_o(vcnt),
    .exz_cnt_o (zcnt)
  );

  task automatic check(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int thr_of(int md);
    return (md == 1) ? 8 : (md == 2) ? 4 : 16;
  endfunction

  // s: +1 positive mark, -1 negative mark, 0 zero, 2 both rails
  task automatic send(int s, int mode, bit c);
    int md, ev, ez;
    bit same;
    @(negedge clk);
    code_sel = mode[1:0];
    pos = (s == 1 || s == 2);
    neg = (s == -1 || s == 2);
    clr = c;
    @(posedge clk);
    #1;
    md = (mode == 3) ? 0 : mode;
    if (mode != m_prev) begin
      m_lm = 0; m_lv = 0; m_zr = 0; m_pend = 0;
    end
    m_prev = mode;
    ev = 0; ez = 0;
    if (s == 2) begin
      ev = 1; m_lm = 0; m_zr = 0; m_pend = 0;
    end else if (s == 0) begin
      m_zr++;
      if (m_zr == thr_of(md)) ez = 1;
      if (md == 1 && m_pend != 0) begin
        if (m_pend == 2) m_pend = 3;
        else begin ev = 1; m_pend = 0; end
      end
    end else begin
      same = (m_lm == s);
      if (md == 2) begin
        if (same) begin
          if (m_lv == s) ev = 1;
          m_lv = s;
        end
      end else if (md == 1) begin
        case (m_pend)
          0: if (same) begin
               if (m_zr == 3) m_pend = 1; else ev = 1;
             end
          1, 4: if (!same && m_lm != 0) m_pend = (m_pend == 1) ? 2 : 0;
                else begin ev = 1; m_pend = 0; end
          3: if (same) m_pend = 4; else begin ev = 1; m_pend = 0; end
          default: begin ev = 1; m_pend = 0; end
        endcase
      end else begin
        ev = same;
      end
      m_lm = s; m_zr = 0;
    end
    if (c) begin e_vc = 0; e_zc = 0; end
    if (ev != 0 && e_vc < 65535) e_vc++;
    if (ez != 0 && e_zc < 65535) e_zc++;
    check(tag, "viol strobe", int'(viol), ev);
    check(tag, "exz strobe", int'(exz), ez);
    check(tag, "viol count", int'(vcnt), e_vc);
    check(tag, "exz count", int'(zcnt), e_zc);
  endtask

  task automatic seq(int mode, int n, int s);
    for (int i = 0; i < n; i++) send(s, mode, 1'b0);
  endtask

  task automatic sweep(int mode, int n);
    for (int i = 0; i < n; i++) begin
      int k = int'($urandom % 32);
      if (k < 12) send(0, mode, 1'b0);
      else if (k < 24) begin gen_last = (gen_last == 1) ? -1 : 1; send(gen_last, mode, 1'b0); end
      else if (k < 27) send((gen_last == 0) ? 1 : gen_last, mode, 1'b0);
      else if (k == 27) send(2, mode, 1'b0);
      else if (k < 30) begin
        int v = (gen_last == 0) ? 1 : gen_last;
        seq(mode, 3, 0); send(v, mode, 0); send(-v, mode, 0);
        send(0, mode, 0); send(-v, mode, 0); send(v, mode, 0);
        gen_last = v;
      end else if (k == 30) begin
        int v = (gen_last == 0) ? 1 : gen_last;
        seq(mode, 3, 0); send(v, mode, 0);
      end else seq(mode, 9, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; code_sel = 2'd0; pos = 0; neg = 0; clr = 0;
    m_lm = 0; m_lv = 0; m_zr = 0; m_pend = 0; m_prev = 0;
    e_vc = 0; e_zc = 0; gen_last = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R10", "reset viol", int'(viol), 0);
    check("R10", "reset exz", int'(exz), 0);
    check("R10", "reset counts", int'(vcnt) + int'(zcnt), 0);

    tag = "R7";  send(1, 0, 0);
    tag = "R1";  send(1, 0, 0); seq(0, 3, 0); send(-1, 0, 0); seq(0, 2, 0); send(-1, 0, 0); send(1, 0, 0);
    tag = "R5";  seq(0, 16, 0);
    tag = "R6";  seq(0, 20, 0); send(-1, 0, 0); seq(0, 16, 0);
    tag = "R2";  send(2, 0, 0); send(1, 0, 0); send(-1, 0, 0);
    tag = "R7";  send(-1, 1, 0);
    tag = "R3";  send(1, 1, 0); seq(1, 3, 0); send(1, 1, 0); send(-1, 1, 0); send(0, 1, 0);
                 send(-1, 1, 0); send(1, 1, 0);
                 seq(1, 3, 0); send(1, 1, 0); send(0, 1, 0);
                 send(-1, 1, 0); send(0, 1, 0); send(-1, 1, 0);
    tag = "R5";  seq(1, 12, 0);
    tag = "R2";  send(2, 1, 0);
    tag = "R7";  send(1, 2, 0);
    tag = "R4";  seq(2, 3, 0); send(1, 2, 0); send(-1, 2, 0); seq(2, 2, 0); send(-1, 2, 0);
                 send(1, 2, 0); seq(2, 2, 0); send(1, 2, 0); seq(2, 3, 0); send(1, 2, 0);
    tag = "R5";  seq(2, 6, 0);
    tag = "R1";  send(1, 3, 0); send(1, 3, 0); seq(3, 16, 0);

    for (int md = 0; md < 4; md++) begin
      tag = (md == 1) ? "R3" : (md == 2) ? "R4" : "R1";
      sweep(md, 1500);
    end

    tag = "R8";  seq(0, 65540, 2);
    tag = "R9";  seq(0, 5, 0); send(2, 0, 1); send(0, 0, 1); send(1, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule